// File: doc/BRIEF.md
# Layer-1 Link Activation Handshake Controller

This block runs the controller side of bringing a time-multiplexed layer-1 link up and down. While the link is deactivated, the bus clock is stopped and the transmit data line is released, so it rests high. The controller watches for bus clock edges. Once the clock is running, it accepts the 4-bit command/indication code that arrives on channel 0 in each frame. A code counts as an indication only after it has been seen in two consecutive frames. A new indication activates the link and sets an interrupt pending flag, and a host mask gates that flag onto the interrupt pin.

The host can also start activation itself by setting a force bit. While the bit is set, the transmit data output is held at zero, and the timing-request code 0 goes out on channel 0 in every frame. The physical device then restarts the clock and answers with an indication, which takes the link to the active state. Data output is enabled once the host clears the force bit. If bus clock edges stop for a parameterised number of system cycles, the controller returns to the deactivated state.

Top module: `l1_act_ctrl`

## Requirements
- R1: After reset, clk_present, link_active, tx_data_en, data_force_low, irq_pending and irq are all 0, and tx_ci and ind_code are both 4'hF.
- R2: clk_present goes to 1 within a few cycles of a bus clock rising edge. It stays at 1 across gaps shorter than TIMEOUT (256) system cycles. After TIMEOUT cycles with no edge it returns to 0, link_active drops and ind_code returns to 4'hF.
- R3: A channel-0 code on frame_stb is taken as an indication only when the same code arrived on the previous strobe. A code seen in one frame only is ignored, and so is every strobe while clk_present is 0.
- R4: A valid indication while the clock is present sets link_active and places the code on ind_code.
- R5: While host_force is 1, data_force_low is 1, tx_ci is 4'h0 (the timing request) and tx_data_en is 0. This holds even after link_active is set.
- R6: With link_active set and host_force at 0, tx_data_en is 1 and tx_ci follows host_ci. In the deactivated state with no force, tx_ci is 4'hF.
- R7: irq_pending is set by each valid indication and stays set until an irq_clr pulse. A set and a clear in the same cycle leave it set.
- R8: irq equals irq_pending AND irq_en. The mask never changes irq_pending.
- R9: Repeating the code already accepted does not set irq_pending again. A different code, once stable, does set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_clk_in | input | 1 | Raw layer-1 bus clock, sampled for edges |
| frame_stb | input | 1 | One-cycle pulse: rx_ci holds this frame's channel-0 code |
| rx_ci | input | 4 | Received channel-0 command/indication code |
| host_force | input | 1 | Host bit: force data low and send timing request |
| host_ci | input | 4 | Code the host sends once the link is active |
| irq_en | input | 1 | Interrupt mask (1 = enabled) |
| irq_clr | input | 1 | One-cycle pulse that clears the pending flag |
| tx_ci | output | 4 | Channel-0 code to transmit |
| data_force_low | output | 1 | Transmit data forced to zero |
| tx_data_en | output | 1 | Normal data output enabled |
| link_active | output | 1 | Link in the active state |
| clk_present | output | 1 | Bus clock currently detected |
| ind_code | output | 4 | Last accepted indication code (4'hF when none) |
| irq_pending | output | 1 | Sticky indication flag |
| irq | output | 1 | Masked interrupt request |

## Verification
The interrupt clear from the host and the setting of the pending flag by a new indication can fall in the same cycle. The bench provokes this by pulsing irq_clr in exactly the cycle that carries the second matching frame strobe. It then checks that irq_pending is still 1 afterwards, because the set has to win. In the same way, the force bit stays asserted while the device's answer activates the link. The bench checks that data stays forced low and that tx_ci stays at the timing request until the host releases the force.

// File: rtl/l1_act_pkg.sv
package l1_act_pkg;
  localparam int CI_W = 4;
  localparam logic [CI_W-1:0] CI_TIMING = 4'h0;
  localparam logic [CI_W-1:0] CI_IDLE   = 4'hF;

  typedef enum logic [1:0] {
    ST_DEACT = 2'd0,
    ST_AWAIT = 2'd1,
    ST_UP    = 2'd2
  } link_st_e;
endpackage

// File: rtl/l1_clk_monitor.sv
module l1_clk_monitor #(
  parameter int TIMEOUT = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_clk_in,
  output logic present
);
  localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [SYNC_STAGES:0] sync_q;
  logic [CW-1:0]        idle_cnt;
  logic                 edge_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], bus_clk_in};
  end

  assign edge_seen = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      present  <= 1'b0;
    end else if (edge_seen) begin
      idle_cnt <= '0;
      present  <= 1'b1;
    end else if (present) begin
      if (idle_cnt == LAST) begin
        present  <= 1'b0;
        idle_cnt <= '0;
      end else begin
        idle_cnt <= idle_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/l1_ci_filter.sv
module l1_ci_filter
  import l1_act_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            present,
  input  logic            frame_stb,
  input  logic [CI_W-1:0] rx_ci,
  output logic            ind_evt,
  output logic [CI_W-1:0] ind_code
);
  logic [CI_W-1:0] prev_code;
  logic            prev_vld;
  logic            acc_vld;
  logic            stable;

  assign stable  = present && frame_stb && prev_vld && (rx_ci == prev_code);
  assign ind_evt = stable && (!acc_vld || (rx_ci != ind_code));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_code <= CI_IDLE;
      prev_vld  <= 1'b0;
      acc_vld   <= 1'b0;
      ind_code  <= CI_IDLE;
    end else if (!present) begin
      prev_vld  <= 1'b0;
      acc_vld   <= 1'b0;
      ind_code  <= CI_IDLE;
    end else if (frame_stb) begin
      prev_code <= rx_ci;
      prev_vld  <= 1'b1;
      if (ind_evt) begin
        ind_code <= rx_ci;
        acc_vld  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/l1_irq_ctrl.sv
module l1_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr,
  input  logic en,
  output logic pending,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pending <= 1'b0;
    else if (set_evt) pending <= 1'b1;
    else if (clr)     pending <= 1'b0;
  end

  assign irq = pending & en;
endmodule

// File: rtl/l1_act_ctrl.sv
module l1_act_ctrl
  import l1_act_pkg::*;
#(
  parameter int TIMEOUT = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_clk_in,
  input  logic            frame_stb,
  input  logic [CI_W-1:0] rx_ci,
  input  logic            host_force,
  input  logic [CI_W-1:0] host_ci,
  input  logic            irq_en,
  input  logic            irq_clr,
  output logic [CI_W-1:0] tx_ci,
  output logic            data_force_low,
  output logic            tx_data_en,
  output logic            link_active,
  output logic            clk_present,
  output logic [CI_W-1:0] ind_code,
  output logic            irq_pending,
  output logic            irq
);
  link_st_e st_q, st_d;
  logic     ind_evt;

  l1_clk_monitor #(.TIMEOUT(TIMEOUT), .SYNC_STAGES(2)) u_clkmon (
    .clk(clk), .rst_n(rst_n), .bus_clk_in(bus_clk_in), .present(clk_present)
  );

  l1_ci_filter u_filt (
    .clk(clk), .rst_n(rst_n), .present(clk_present), .frame_stb(frame_stb),
    .rx_ci(rx_ci), .ind_evt(ind_evt), .ind_code(ind_code)
  );

  l1_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n), .set_evt(ind_evt), .clr(irq_clr), .en(irq_en),
    .pending(irq_pending), .irq(irq)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_DEACT: begin
        if (ind_evt)         st_d = ST_UP;
        else if (host_force) st_d = ST_AWAIT;
      end
      ST_AWAIT: begin
        if (ind_evt)          st_d = ST_UP;
        else if (!host_force) st_d = ST_DEACT;
      end
      ST_UP: begin
        if (!clk_present) st_d = host_force ? ST_AWAIT : ST_DEACT;
      end
      default: st_d = ST_DEACT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_DEACT;
    else        st_q <= st_d;
  end

  assign link_active    = (st_q == ST_UP);
  assign data_force_low = host_force;
  assign tx_data_en     = link_active && !host_force;

  always_comb begin
    if (host_force)       tx_ci = CI_TIMING;
    else if (link_active) tx_ci = host_ci;
    else                  tx_ci = CI_IDLE;
  end
endmodule

// File: rtl/l1_act_ctrl_chk.sv
module l1_act_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_stb,
  input logic host_force,
  input logic irq_clr,
  input logic clk_present,
  input logic link_active,
  input logic tx_data_en,
  input logic data_force_low,
  input logic irq_pending
);
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending && !irq_clr |=> irq_pending);

  a_r3_set_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pending) |-> $past(frame_stb));

  a_r2_loss_drops_link: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_present) |=> !link_active);

  a_r4_up_needs_clock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_active) |-> $past(clk_present));

  a_r5_force_blocks_data: assert property (@(posedge clk) disable iff (!rst_n)
    host_force |-> !tx_data_en && data_force_low);
endmodule

bind l1_act_ctrl l1_act_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .host_force(host_force),
  .irq_clr(irq_clr), .clk_present(clk_present), .link_active(link_active),
  .tx_data_en(tx_data_en), .data_force_low(data_force_low),
  .irq_pending(irq_pending)
);

// File: tb/l1_act_ctrl_tb.sv
module l1_act_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic bus_clk_in = 0, frame_stb = 0, host_force = 0, irq_en = 0, irq_clr = 0;
  logic [3:0] rx_ci = 0, host_ci = 4'h5;
  logic [3:0] tx_ci, ind_code;
  logic data_force_low, tx_data_en, link_active, clk_present, irq_pending, irq;
  logic bclk_on = 0;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  initial forever begin
    #20;
    if (bclk_on) bus_clk_in = ~bus_clk_in;
  end

  l1_act_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_clk_in(bus_clk_in), .frame_stb(frame_stb),
    .rx_ci(rx_ci), .host_force(host_force), .host_ci(host_ci), .irq_en(irq_en),
    .irq_clr(irq_clr), .tx_ci(tx_ci), .data_force_low(data_force_low),
    .tx_data_en(tx_data_en), .link_active(link_active), .clk_present(clk_present),
    .ind_code(ind_code), .irq_pending(irq_pending), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [3:0] c, input logic clr_too);
    @(negedge clk);
    frame_stb = 1; rx_ci = c; irq_clr = clr_too;
    @(negedge clk);
    frame_stb = 0; irq_clr = 0;
    cyc(6);
  endtask

  task automatic pulse_clr();
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
    cyc(1);
  endtask

  task automatic t_reset();
    cyc(1);
    chk("R1 clk_present", clk_present, 0);
    chk("R1 link_active", link_active, 0);
    chk("R1 tx_data_en", tx_data_en, 0);
    chk("R1 data_force_low", data_force_low, 0);
    chk("R1 irq_pending", irq_pending, 0);
    chk("R1 irq", irq, 0);
    chk("R1 tx_ci", tx_ci, 4'hF);
    chk("R1 ind_code", ind_code, 4'hF);
  endtask

  task automatic t_clock();
    bclk_on = 1; cyc(40);
    chk("R2 present after edges", clk_present, 1);
    chk("R2 not yet active", link_active, 0);
    bclk_on = 0; cyc(150);
    chk("R2 short gap keeps present", clk_present, 1);
    bclk_on = 1; cyc(20);
  endtask

  task automatic t_single();
    send_frame(4'h3, 0);
    send_frame(4'h5, 0);
    chk("R3 single frames ignored pending", irq_pending, 0);
    chk("R3 single frames ignored link", link_active, 0);
  endtask

  task automatic t_device_act();
    send_frame(4'h7, 0);
    send_frame(4'h7, 0);
    chk("R4 link active", link_active, 1);
    chk("R4 ind_code", ind_code, 4'h7);
    chk("R7 pending set", irq_pending, 1);
    chk("R8 masked irq", irq, 0);
    chk("R6 data enabled", tx_data_en, 1);
    chk("R6 tx_ci follows host", tx_ci, 4'h5);
    irq_en = 1; cyc(1);
    chk("R8 unmasked irq", irq, 1);
    irq_en = 0; cyc(1);
    chk("R8 mask leaves pending", irq_pending, 1);
    pulse_clr();
    chk("R7 clear", irq_pending, 0);
    send_frame(4'h7, 0);
    send_frame(4'h7, 0);
    chk("R9 same code no retrigger", irq_pending, 0);
    send_frame(4'hC, 0);
    send_frame(4'hC, 0);
    chk("R9 new code retriggers", irq_pending, 1);
    chk("R9 new ind_code", ind_code, 4'hC);
  endtask

  task automatic t_collide();
    pulse_clr();
    chk("R7 cleared before collide", irq_pending, 0);
    send_frame(4'hA, 0);
    send_frame(4'hA, 1);
    chk("R7 set wins over clear", irq_pending, 1);
  endtask

  task automatic t_loss();
    pulse_clr();
    bclk_on = 0; cyc(300);
    chk("R2 clock lost", clk_present, 0);
    chk("R2 link dropped", link_active, 0);
    chk("R2 ind_code idle", ind_code, 4'hF);
    chk("R6 idle tx_ci", tx_ci, 4'hF);
    send_frame(4'h9, 0);
    send_frame(4'h9, 0);
    chk("R3 no clock strobes ignored", irq_pending, 0);
    chk("R3 no clock stays down", link_active, 0);
  endtask

  task automatic t_host_act();
    host_force = 1; cyc(2);
    chk("R5 force low", data_force_low, 1);
    chk("R5 timing code", tx_ci, 4'h0);
    chk("R5 data disabled", tx_data_en, 0);
    bclk_on = 1; cyc(40);
    send_frame(4'h4, 0);
    send_frame(4'h4, 0);
    chk("R4 answer activates", link_active, 1);
    chk("R5 still forced", tx_data_en, 0);
    chk("R5 still timing code", tx_ci, 4'h0);
    host_force = 0; cyc(1);
    chk("R6 released data", tx_data_en, 1);
    chk("R6 released tx_ci", tx_ci, 4'h5);
    chk("R6 force off", data_force_low, 0);
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    t_reset();
    t_clock();
    t_single();
    t_device_act();
    t_collide();
    t_loss();
    t_host_act();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule